// File: doc/BRIEF.md
# Event Interrupt and Soft-Reset Register Unit

This unit sits beside a two-wire bus master engine and turns its event pulses into one level-sensitive interrupt. Each of eight single-cycle event inputs sets a sticky bit in a status register. A per-bit enable register selects which captured events count. A separate master-enable bit then gates the combined result onto the interrupt output. Software clears captured events by writing ones back to the status register.

The same register port holds a keyed soft-reset register. Only one exact 32-bit value triggers a reset. That value produces a one-cycle reset pulse for the engine, and the same write also wipes the status and enable registers. The register port is a plain single-cycle write strobe with a byte offset and a combinational read of the addressed register. Adapting it to a standard bus is left to a wrapper.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, all three registers read zero, `irq_out` is low and `soft_rst_pulse` is low.
- R2: Status and enable bit i both belong to `ev_pulse[i]`, with this event map: 0 arbitration lost, 1 transmit error or transfer done, 2 transmit FIFO empty, 3 receive FIFO at threshold, 4 bus idle, 5 addressed as slave, 6 no longer addressed as slave, 7 transmit FIFO half empty. The status register (offset 0x20) reads these bits in positions 7:0, and bits 31:8 read zero.
- R3: An event pulse sets its status bit in the cycle after the pulse. The bit then stays set until it is cleared.
- R4: A write to offset 0x20 clears every status bit whose data bit is 1 and leaves the other status bits unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 stores data bits 7:0 and reads them back in bits 7:0. Its bits 31:8 read zero.
- R6: The master enable at offset 0x1C stores only data bit 31 and reads back in bit 31. All other bits of that offset read zero.
- R7: `irq_out` is 1 exactly when the master enable is 1 and at least one bit of (status AND enable) is 1. It follows the registers with no extra delay.
- R8: Writing exactly 32'h0000000A to offset 0x40 drives `soft_rst_pulse` high for the one cycle that follows the write. Any other value written there has no effect. Offset 0x40 reads zero.
- R9: A key write clears the status and enable registers at the same edge that raises the pulse, and events in that cycle are dropped. The master enable keeps its value.
- R10: Offsets with no register read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_pulse | input | 8 | Event pulses from the bus engine |
| irq_out | output | 1 | Interrupt request |
| soft_rst_pulse | output | 1 | One-cycle reset request to the engine |

## Verification
The sticky path is first tried with single events one at a time, which shows that each event lands on its own bit. Overlapping clears and events then separate a correct event-wins merge from a clear-wins merge. Enable and master-enable patterns that miss, hit or partly hit the captured bits separate correct AND gating from OR gating or a missing master gate. Key writes that are near misses (wrong low nibble, a stray upper bit, the right value at the wrong offset) separate a full 32-bit compare from a partial one. A final stretch of random traffic is compared cycle by cycle with a behavioural model, reading every offset.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int EVT_W   = 8;
  localparam int WORD_W  = 32;

  localparam logic [WORD_W-1:0] OFF_MASTER_EN = 32'h0000_001C;
  localparam logic [WORD_W-1:0] OFF_STATUS    = 32'h0000_0020;
  localparam logic [WORD_W-1:0] OFF_ENABLE    = 32'h0000_0028;
  localparam logic [WORD_W-1:0] OFF_SOFT_RST  = 32'h0000_0040;
  localparam logic [WORD_W-1:0] SOFT_RST_KEY  = 32'h0000_000A;

  localparam int MASTER_EN_BIT = 31;

  typedef enum logic [2:0] {
    EV_ARB_LOST   = 3'd0,
    EV_TX_ERR     = 3'd1,
    EV_TX_EMPTY   = 3'd2,
    EV_RX_LEVEL   = 3'd3,
    EV_BUS_IDLE   = 3'd4,
    EV_SLV_ADDR   = 3'd5,
    EV_SLV_UNADDR = 3'd6,
    EV_TX_HALF    = 3'd7
  } evt_idx_e;

  typedef struct packed {
    logic wr_master;
    logic wr_status;
    logic wr_enable;
    logic key_hit;
    logic key_miss;
  } reg_strobe_t;

  // next value of one sticky bit: a wipe beats everything, an event beats a clear
  function automatic logic sticky_bit(input logic cur, input logic ev,
                                      input logic clr, input logic wipe);
    if (wipe) return 1'b0;
    return (cur & ~clr) | ev;
  endfunction

  // interrupt level from the three registers
  function automatic logic irq_level(input logic master,
                                     input logic [EVT_W-1:0] stat,
                                     input logic [EVT_W-1:0] en);
    return master & (|(stat & en));
  endfunction

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output reg_strobe_t       strobe
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] addr_ext;
  logic              at_rst;

  assign addr_ext = {{PAD_W{1'b0}}, bus_addr};
  assign at_rst   = bus_wr && (addr_ext == OFF_SOFT_RST);

  always_comb begin
    strobe.wr_master = bus_wr && (addr_ext == OFF_MASTER_EN);
    strobe.wr_status = bus_wr && (addr_ext == OFF_STATUS);
    strobe.wr_enable = bus_wr && (addr_ext == OFF_ENABLE);
    strobe.key_hit   = at_rst && (bus_wdata == SOFT_RST_KEY);
    strobe.key_miss  = at_rst && (bus_wdata != SOFT_RST_KEY);
  end

  // at most one register is written per cycle
  always_comb begin
    a_r10_one_target: assert ($countones({strobe.wr_master, strobe.wr_status,
                                         strobe.wr_enable, strobe.key_hit,
                                         strobe.key_miss}) <= 1)
      else $error("decode selected more than one register");
  end
endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic               wipe,
  output logic [NUM_EVT-1:0] stat_q
);
  logic [NUM_EVT-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_mask : '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= sticky_bit(stat_q[i], ev_in[i], clr_eff[i], wipe);
    end
  end

  // R3: every pulsed event is captured on the next edge unless wiped
  a_r3_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && ev_in != '0) |=> ((stat_q & $past(ev_in)) == $past(ev_in)))
    else $error("event pulse not captured");

  // R4: a cleared bit with no event in the same cycle reads zero next
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !wipe) |=> ((stat_q & $past(clr_mask & ~ev_in)) == '0))
    else $error("write-one-to-clear failed");

  // R3: bits not cleared and not wiped never drop
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && !clr_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
    else $error("status bit lost without a clear");
endmodule

// File: rtl/evt_soft_reset.sv
module evt_soft_reset (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  input  logic key_miss,
  output logic pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= key_hit;
  end

  // R8: the pulse only ever follows a key write
  a_r8_pulse_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(key_hit))
    else $error("reset pulse without key");

  // R8: a wrong value written to the reset offset gives no pulse
  a_r8_bad_key_silent: assert property (@(posedge clk) disable iff (!rst_n)
    key_miss |=> !pulse_q)
    else $error("reset pulse after wrong key");
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_EVT = EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] ev_pulse,
  output logic               irq_out,
  output logic               soft_rst_pulse
);
  localparam int PAD_W  = WORD_W - ADDR_W;
  localparam int HIGH_W = WORD_W - NUM_EVT;

  reg_strobe_t        strobe;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] en_q;
  logic               master_q;
  logic [NUM_EVT-1:0] pending;
  logic [WORD_W-1:0]  addr_ext;

  evt_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .strobe    (strobe)
  );

  evt_sticky_bank #(.NUM_EVT(NUM_EVT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (ev_pulse),
    .clr_wr   (strobe.wr_status),
    .clr_mask (bus_wdata[NUM_EVT-1:0]),
    .wipe     (strobe.key_hit),
    .stat_q   (stat_q)
  );

  evt_soft_reset u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_hit  (strobe.key_hit),
    .key_miss (strobe.key_miss),
    .pulse_q  (soft_rst_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= '0;
    else if (strobe.key_hit)   en_q <= '0;
    else if (strobe.wr_enable) en_q <= bus_wdata[NUM_EVT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                master_q <= 1'b0;
    else if (strobe.wr_master) master_q <= bus_wdata[MASTER_EN_BIT];
  end

  assign pending = stat_q & en_q;
  assign irq_out = irq_level(master_q, stat_q, en_q);

  assign addr_ext = {{PAD_W{1'b0}}, bus_addr};
  always_comb begin
    bus_rdata = '0;
    if (addr_ext == OFF_MASTER_EN)   bus_rdata[MASTER_EN_BIT] = master_q;
    else if (addr_ext == OFF_STATUS) bus_rdata = {{HIGH_W{1'b0}}, stat_q};
    else if (addr_ext == OFF_ENABLE) bus_rdata = {{HIGH_W{1'b0}}, en_q};
  end

  // R7: interrupt only with master enable and a pending bit
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master_q && pending != '0))
    else $error("interrupt without cause");

  // R9: during the reset pulse status and enable are already wiped
  a_r9_wiped_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (stat_q == '0 && en_q == '0))
    else $error("registers not wiped by soft reset");

  // R9: the master enable survives a key write
  a_r9_master_kept: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $stable(master_q))
    else $error("master enable changed by soft reset");
endmodule

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [7:0]  ev_pulse = 8'h00;
  logic        irq_out;
  logic        soft_rst_pulse;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural model state
  int m_stat = 0;
  int m_en = 0;
  int m_master = 0;
  int m_pulse = 0;

  always #4 clk = ~clk;

  evt_irq_unit u_evt_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .irq_out(irq_out), .soft_rst_pulse(soft_rst_pulse)
  );

  function automatic int model_read(int a);
    case (a)
      'h1C: return m_master << 31;
      'h20: return m_stat;
      'h28: return m_en;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0; m_en <= 0; m_master <= 0; m_pulse <= 0;
    end else begin
      int s;
      s = m_stat;
      if (bus_wr && bus_addr == 8'h40 && bus_wdata == 32'hA) begin
        m_stat  <= 0;
        m_en    <= 0;
        m_pulse <= 1;
      end else begin
        m_pulse <= 0;
        if (bus_wr && bus_addr == 8'h20) s = s & ~int'(bus_wdata[7:0]);
        m_stat <= s | int'(ev_pulse);
        if (bus_wr && bus_addr == 8'h28) m_en <= int'(bus_wdata[7:0]);
      end
      if (bus_wr && bus_addr == 8'h1C) m_master <= int'(bus_wdata[31]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_irq;
      exp_irq = (m_master != 0 && (m_stat & m_en) != 0) ? 1 : 0;
      n_cmp++;
      if (int'(bus_rdata) != model_read(int'(bus_addr))) begin
        n_bad++;
        $display("FAIL %s rdata @%0h: actual %h expected %h", cur_req, bus_addr,
                 bus_rdata, model_read(int'(bus_addr)));
      end
      n_cmp++;
      if (int'(irq_out) != exp_irq) begin
        n_bad++;
        $display("FAIL %s irq_out: actual %0d expected %0d", cur_req, irq_out, exp_irq);
      end
      n_cmp++;
      if (int'(soft_rst_pulse) != m_pulse) begin
        n_bad++;
        $display("FAIL %s soft_rst_pulse: actual %0d expected %0d", cur_req,
                 soft_rst_pulse, m_pulse);
      end
    end
  end

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] ev);
    @(posedge clk); #2;
    bus_wr = wr; bus_addr = a; bus_wdata = d; ev_pulse = ev;
  endtask

  task automatic idle_read(input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) step(1'b0, a, 32'h0, 8'h00);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    cur_req = "R1";
    idle_read(8'h1C, 2); idle_read(8'h20, 2); idle_read(8'h28, 2); idle_read(8'h40, 2);

    cur_req = "R2";  // each event lands on its own bit (R3 sticky)
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 8'h20, 32'h0, 8'h01 << i);
      idle_read(8'h20, 2);
    end
    cur_req = "R3";
    step(1'b0, 8'h20, 32'h0, 8'h00);
    idle_read(8'h20, 3);

    cur_req = "R4";
    step(1'b1, 8'h20, 32'h0000_000F, 8'h00);
    idle_read(8'h20, 2);
    step(1'b1, 8'h20, 32'h0000_00F0, 8'h30);   // event wins on bits 5:4
    idle_read(8'h20, 2);
    step(1'b1, 8'h20, 32'hFFFF_FF00, 8'h00);   // zeros in 7:0 clear nothing
    idle_read(8'h20, 2);

    cur_req = "R5";
    step(1'b1, 8'h28, 32'hFFFF_FF5A, 8'h00);
    idle_read(8'h28, 2);

    cur_req = "R6";
    step(1'b1, 8'h1C, 32'h7FFF_FFFF, 8'h00);
    idle_read(8'h1C, 2);
    step(1'b1, 8'h1C, 32'h8000_0000, 8'h00);
    idle_read(8'h1C, 2);

    cur_req = "R7";  // status 0x30, enable 0x5A: bit 4 overlaps
    idle_read(8'h20, 2);
    step(1'b1, 8'h20, 32'h0000_0010, 8'h00);    // remove overlap -> irq low
    idle_read(8'h20, 2);
    step(1'b0, 8'h20, 32'h0, 8'h02);            // enabled bit arrives -> high
    idle_read(8'h20, 2);
    step(1'b1, 8'h1C, 32'h0, 8'h00);            // master off -> low
    idle_read(8'h20, 2);
    step(1'b1, 8'h1C, 32'h8000_0000, 8'h00);
    idle_read(8'h20, 2);

    cur_req = "R8";
    step(1'b1, 8'h40, 32'h0000_000B, 8'h00); idle_read(8'h40, 2);
    step(1'b1, 8'h40, 32'h1000_000A, 8'h00); idle_read(8'h28, 2);
    step(1'b1, 8'h48, 32'h0000_000A, 8'h00); idle_read(8'h20, 2);
    step(1'b1, 8'h40, 32'h0000_000A, 8'h00); idle_read(8'h40, 3);

    cur_req = "R9";
    step(1'b1, 8'h28, 32'h0000_00FF, 8'h0F);
    step(1'b1, 8'h40, 32'h0000_000A, 8'hF0);   // events dropped by the wipe
    idle_read(8'h20, 1); idle_read(8'h28, 1); idle_read(8'h1C, 2);

    cur_req = "R10";
    step(1'b1, 8'h24, 32'hFFFF_FFFF, 8'h00); idle_read(8'h24, 2);
    step(1'b1, 8'h2C, 32'hFFFF_FFFF, 8'h00); idle_read(8'h28, 1); idle_read(8'h20, 1);

    cur_req = "R7";  // random traffic against the model
    for (int k = 0; k < 2000; k++) begin
      int    sel;
      logic [7:0]  a;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: a = 8'h20;
        2:    a = 8'h28;
        3:    a = 8'h1C;
        4:    a = 8'h40;
        default: a = 8'h20 + 8'(4 * $urandom_range(0, 10));
      endcase
      d = ($urandom_range(0, 7) == 0) ? 32'hA : $urandom;
      step(($urandom_range(0, 3) == 0), a, d, 8'($urandom) & 8'($urandom));
    end
    idle_read(8'h20, 2);
    report();
  end
endmodule